// File: doc/BRIEF.md
# Sticky Event Interrupt Collector

The block gathers eight event lines into one level-type interrupt output that is driven low while the interrupt is active. A high level on an event input during a clock cycle sets the matching status bit at that cycle's clock edge. The bit then stays set until software clears it. A mask register decides which status bits may drive the output. A mask bit of 1 blocks its event, and reset sets every mask bit to 1.

Software reaches the block through a plain synchronous register port. The port has a 2-bit address, write data, a write strobe and registered read data. Address 0 reads the sticky status and ignores writes. Address 1 is the mask, which can be read and written. Address 2 is a write-1-to-set register that lets software raise status bits to test the interrupt path. Address 3 is a write-1-to-clear register. Addresses 2 and 3 read as zero. Event positions 3 and 7 are reserved and never become set.

Top module: `evt_irq_collect`

## Requirements
- R1: While reset is high and on the cycle after it, the status reads 0x00, the mask reads 0xFF, irq_n is 1 and rd_data is 0.
- R2: If evt[i] is high during a cycle, status bit i is set at that clock edge. The bit stays set after evt[i] falls, until it is cleared through address 3.
- R3: Status bits 3 and 7 always read 0, whatever the events or set-register writes.
- R4: A write to address 1 stores wr_data as the mask. Reading address 1 returns it.
- R5: A write to address 2 sets each status bit whose wr_data bit is 1. Bits written as 0 are unchanged.
- R6: A write to address 3 clears each status bit whose wr_data bit is 1. Bits written as 0 are unchanged.
- R7: If an event and a clear write hit the same bit in the same cycle, the bit ends up set.
- R8: irq_n is 0 exactly when, at the previous clock edge, some status bit was set with its mask bit 0. It therefore changes one clock after the status or mask changes.
- R9: Reading address 0 returns the status bits regardless of the mask.
- R10: Writes to address 0 have no effect. Reads of addresses 2 and 3 return 0.
- R11: rd_data is registered. After an edge it holds the register at the address presented before that edge, with the contents it had before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt | input | 8 | Event lines, active high |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| irq_n | output | 1 | Interrupt, active low, level |

## Verification
Status and mask updates take effect at the edge that samples the event or write. irq_n follows one edge later. rd_data shows, just after an edge, the contents from before that edge. The reference model in the bench advances at each rising edge from the inputs it sees. It compares both outputs at the falling edge that follows. Directed checks read a register by holding its address over one edge and sampling at the next falling edge. They check irq_n both one and two edges after a mask or clear write, which confirms the single cycle of output latency.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] A_MASK = 2'd1;
  localparam logic [ADDR_W-1:0] A_SET  = 2'd2;
  localparam logic [ADDR_W-1:0] A_CLR  = 2'd3;
endpackage

// File: rtl/evt_reg_decode.sv
module evt_reg_decode
  import evt_irq_pkg::*;
#(
  parameter int unsigned N_EVT = 8
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_EVT-1:0]  wr_data,
  output logic [N_EVT-1:0]  set_vec,
  output logic [N_EVT-1:0]  clr_vec,
  output logic              mask_we
);
  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    mask_we = 1'b0;
    if (wr_en) begin
      case (addr)
        A_MASK:  mask_we = 1'b1;
        A_SET:   set_vec = wr_data;
        A_CLR:   clr_vec = wr_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int unsigned      N_EVT = 8,
  parameter logic [N_EVT-1:0] RSVD  = 8'h88
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EVT-1:0] evt,
  input  logic [N_EVT-1:0] set_vec,
  input  logic [N_EVT-1:0] clr_vec,
  output logic [N_EVT-1:0] status
);
  for (genvar i = 0; i < N_EVT; i++) begin : g_bit
    if (RSVD[i]) begin : g_rsvd
      assign status[i] = 1'b0;
    end else begin : g_live
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst)
          bit_q <= 1'b0;
        else if (evt[i] || set_vec[i])
          bit_q <= 1'b1;      // a hardware event outranks a clear
        else if (clr_vec[i])
          bit_q <= 1'b0;
      end
      assign status[i] = bit_q;
    end
  end
endmodule

// File: rtl/evt_mask_reg.sv
module evt_mask_reg #(
  parameter int unsigned N_EVT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mask_we,
  input  logic [N_EVT-1:0] wr_data,
  output logic [N_EVT-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst)          mask <= '1;
    else if (mask_we) mask <= wr_data;
  end
endmodule

// File: rtl/evt_irq_out.sv
module evt_irq_out
  import evt_irq_pkg::*;
#(
  parameter int unsigned N_EVT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EVT-1:0]  status,
  input  logic [N_EVT-1:0]  mask,
  input  logic [ADDR_W-1:0] addr,
  output logic [N_EVT-1:0]  rd_data,
  output logic              irq_n
);
  logic [N_EVT-1:0] rd_mux;

  always_comb begin
    case (addr)
      A_STAT:  rd_mux = status;
      A_MASK:  rd_mux = mask;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq_n   <= 1'b1;
    end else begin
      rd_data <= rd_mux;
      irq_n   <= ~|(status & ~mask);
    end
  end
endmodule

// File: rtl/evt_irq_collect.sv
module evt_irq_collect
  import evt_irq_pkg::*;
#(
  parameter int unsigned      N_EVT = 8,
  parameter logic [N_EVT-1:0] RSVD  = 8'h88
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EVT-1:0]  evt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_EVT-1:0]  wr_data,
  output logic [N_EVT-1:0]  rd_data,
  output logic              irq_n
);
  logic [N_EVT-1:0] set_vec, clr_vec, status_q, mask_q;
  logic             mask_we;

  evt_reg_decode #(.N_EVT(N_EVT)) u_dec (
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .set_vec(set_vec), .clr_vec(clr_vec), .mask_we(mask_we)
  );

  evt_status_bank #(.N_EVT(N_EVT), .RSVD(RSVD)) u_stat (
    .clk(clk), .rst(rst), .evt(evt),
    .set_vec(set_vec), .clr_vec(clr_vec), .status(status_q)
  );

  evt_mask_reg #(.N_EVT(N_EVT)) u_mask (
    .clk(clk), .rst(rst), .mask_we(mask_we), .wr_data(wr_data), .mask(mask_q)
  );

  evt_irq_out #(.N_EVT(N_EVT)) u_out (
    .clk(clk), .rst(rst), .status(status_q), .mask(mask_q),
    .addr(addr), .rd_data(rd_data), .irq_n(irq_n)
  );
endmodule

// File: rtl/evt_irq_checker.sv
module evt_irq_checker
  import evt_irq_pkg::*;
#(
  parameter int unsigned      N_EVT = 8,
  parameter logic [N_EVT-1:0] RSVD  = 8'h88
) (
  input logic              clk,
  input logic              rst,
  input logic [N_EVT-1:0]  evt,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [N_EVT-1:0]  wr_data,
  input logic [N_EVT-1:0]  st,
  input logic [N_EVT-1:0]  mk,
  input logic              irq_n
);
  p_reset_vals_r1: assert property (@(posedge clk)
    rst |=> (st == '0 && mk == '1 && irq_n));

  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (st & RSVD) == '0);

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((st & $past(evt & ~RSVD)) == $past(evt & ~RSVD)));

  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == A_CLR) |=> ((st & $past(st)) == $past(st)));

  p_mask_write_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_MASK) |=> (mk == $past(wr_data)));

  p_irq_level_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_n == ~|$past(st & ~mk)));
endmodule

bind evt_irq_collect evt_irq_checker #(.N_EVT(N_EVT), .RSVD(RSVD)) u_chk (
  .clk(clk), .rst(rst), .evt(evt), .wr_en(wr_en), .addr(addr),
  .wr_data(wr_data), .st(status_q), .mk(mask_q), .irq_n(irq_n)
);

// File: tb/evt_irq_collect_test.sv
module evt_irq_collect_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] evt = '0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq_n;

  int checks = 0;
  int fails = 0;
  bit started = 0;
  string phase = "R1";

  // reference model state
  logic [7:0] m_st = 8'h00, m_mk = 8'hFF, m_rd = 8'h00;
  logic       m_irq = 1'b1;

  evt_irq_collect uut (
    .clk(clk), .rst(rst), .evt(evt), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    logic [7:0] setv, clrv;
    started = 1;
    if (rst) begin
      m_st = 8'h00; m_mk = 8'hFF; m_rd = 8'h00; m_irq = 1'b1;
    end else begin
      m_rd  = (addr == 2'd0) ? m_st : (addr == 2'd1) ? m_mk : 8'h00;
      m_irq = ((m_st & ~m_mk) == 8'h00);
      setv  = (wr_en && addr == 2'd2) ? wr_data : 8'h00;
      clrv  = (wr_en && addr == 2'd3) ? wr_data : 8'h00;
      m_st  = ((m_st & ~clrv) | setv | evt) & 8'h77;
      if (wr_en && addr == 2'd1) m_mk = wr_data;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (started) begin
      chk({phase, " irq_n model"}, {7'd0, irq_n}, {7'd0, m_irq});
      chk({phase, " rd_data model (R11)"}, rd_data, m_rd);
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] a, input string req, input logic [7:0] exp);
    wr_en = 1'b0; addr = a;
    step();
    chk(req, rd_data, exp);
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) step();
    chk("R1 irq_n in reset", {7'd0, irq_n}, 8'h01);
    chk("R1 rd_data in reset", rd_data, 8'h00);
    rst = 1'b0;
    rd(2'd1, "R1 mask after reset", 8'hFF);
    rd(2'd0, "R1 status after reset", 8'h00);

    phase = "R2";
    evt = 8'hFF; step(); evt = 8'h00;
    rd(2'd0, "R2/R3 status after all events", 8'h77);
    chk("R8 masked events keep irq high", {7'd0, irq_n}, 8'h01);

    phase = "R8";
    wr(2'd1, 8'hFE);
    chk("R8 irq one edge after mask write", {7'd0, irq_n}, 8'h01);
    step();
    chk("R8 irq two edges after mask write", {7'd0, irq_n}, 8'h00);
    rd(2'd1, "R4 mask readback", 8'hFE);
    rd(2'd0, "R9 status ignores mask", 8'h77);

    phase = "R10";
    wr(2'd0, 8'h00);
    rd(2'd0, "R10 status write ignored", 8'h77);
    rd(2'd2, "R10 set reg reads zero", 8'h00);
    rd(2'd3, "R10 clear reg reads zero", 8'h00);

    phase = "R6";
    wr(2'd3, 8'h01);
    chk("R8 irq still low one edge after clear", {7'd0, irq_n}, 8'h00);
    step();
    chk("R8 irq released after clear", {7'd0, irq_n}, 8'h01);
    rd(2'd0, "R6 clear bit0 only", 8'h76);

    phase = "R7";
    evt = 8'h04; wr(2'd3, 8'h04); evt = 8'h00;
    rd(2'd0, "R7 event beats clear", 8'h76);

    phase = "R6";
    wr(2'd3, 8'hFF);
    rd(2'd0, "R6 clear all", 8'h00);

    phase = "R5";
    wr(2'd2, 8'h89);
    rd(2'd0, "R5/R3 set reg, reserved stay zero", 8'h01);
    chk("R5 test set raises irq", {7'd0, irq_n}, 8'h00);
    wr(2'd2, 8'h00);
    rd(2'd0, "R5 zero write no effect", 8'h01);

    phase = "R11";
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      evt     = lfsr[7:0] & lfsr[15:8] & {8{lfsr[3]}};
      wr_en   = lfsr[9] & lfsr[4];
      addr    = lfsr[12:11];
      wr_data = lfsr[15:8] ^ lfsr[7:0];
      step();
    end
    evt = '0; wr_en = 1'b0;
    step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule